// File: doc/BRIEF.md
# Indexed Effective-Address Sequencer

This block turns one indexed-mode postbyte into a 16-bit effective address for an 8-bit processor. A pulse on `start` captures the postbyte, the four index registers, both accumulators and the program counter, which points just past the postbyte. The block then reads any inline offset bytes through a byte-wide request/acknowledge memory port. It adds the offset to the selected base, and for memory-indirect forms it reads a 16-bit pointer from the computed address. It finishes with a one-cycle `done` pulse that carries the address, the extra cycle and byte cost of the form, and an illegal-mode flag.

For the auto-increment and auto-decrement forms the block also returns the new index register value, with a write-enable that is asserted together with `done`. The caller owns the register file, decodes the opcode and performs the operand access.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 pick the base register (00 X, 01 Y, 10 U, 11 S). On a write-back, `wb_sel` carries that same code.
- R2: With bit 7 clear, bits 4:0 are a signed offset added to the base. The cost is 1 cycle and 0 bytes, and the memory port is not used.
- R3: With bit 7 set, form 0100 adds nothing, form 1000 adds a sign-extended byte, and form 1001 adds a 16-bit word. Offset bytes are read high byte first, starting at `pc_next`. Direct costs are 0/0, 1/1 and 4/2 (cycles/bytes).
- R4: Form 0110 adds sign-extended A and form 0101 adds sign-extended B, each at a direct cost of 1 cycle. Form 1011 adds D = {A,B} at a direct cost of 4 cycles. None of these forms reads a byte.
- R5: Forms 0000 and 0001 use the old base as the address and write back base+1 or base+2. Their direct costs are 2 and 3 cycles. `wb_en` is high only in the `done` cycle.
- R6: Forms 0010 and 0011 subtract 1 or 2 from the base first, use the result as the address, and write it back. Their direct costs are 2 and 3 cycles.
- R7: Forms 1100 and 1101 add an 8-bit or 16-bit offset to `pc_next` plus the number of offset bytes. Bits 6:5 are ignored, there is no write-back, and the direct costs are 1/1 and 5/2.
- R8: Bit 4 set makes a form indirect. A 16-bit pointer is read high byte first at the computed address and becomes `ea`. The cycle cost is the direct cost plus 3.
- R9: Postbyte 0x9F reads a 16-bit address from `pc_next` and then a pointer from that address. It costs 5 cycles and 2 bytes.
- R10: The following postbytes are illegal: forms 0111, 1010, 1110 and 1111 with bit 7 set (0x9F excepted), and forms 0000 and 0010 with bit 4 set. An illegal postbyte gives `done` with `illegal`=1, zero costs, no write-back and no memory request.
- R11: After reset `done`, `mem_req` and `wb_en` are low. `done` lasts exactly one cycle, and `start` is ignored until the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `postbyte` (taken only when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_u | input | 16 | Stack register U |
| reg_s | input | 16 | Stack register S |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_next | input | 16 | Program counter just past the postbyte |
| mem_req | output | 1 | Byte read request, held until acknowledged |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read acknowledge, one cycle, with data |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| extra_cycles | output | 4 | Extra cycle cost of the form |
| extra_bytes | output | 2 | Extra byte cost of the form |
| illegal | output | 1 | Postbyte is not a legal form |
| wb_en | output | 1 | Write back the updated index register |
| wb_sel | output | 2 | Register to write back |
| wb_value | output | 16 | Updated index register value |

## Verification
In the indirect double-step forms (,R++ and ,--R with bit 4 set), the register write-back and the pointer result fall in the same `done` cycle. `ea` is then the pointer fetched through the bus, while `wb_value` is the stepped register. The bench provokes this by mixing these postbytes into random traffic with random register values and a random acknowledge delay. It checks both values in that one cycle against a model that reads the pointer at the old base for ,R++ and at base-2 for ,--R. Extra `start` pulses during busy cycles confirm that a second postbyte cannot disturb the running sequence.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFS,
        ST_CALC,
        ST_PTR,
        ST_DONE
    } state_e;

    typedef enum logic [3:0] {
        FM_OFS5,
        FM_NONE,
        FM_OFS8,
        FM_OFS16,
        FM_ACCA,
        FM_ACCB,
        FM_ACCD,
        FM_INC1,
        FM_INC2,
        FM_DEC1,
        FM_DEC2,
        FM_PC8,
        FM_PC16,
        FM_EXT,
        FM_BAD
    } form_e;

    typedef struct packed {
        form_e      form;
        logic       ind;
        logic       bad;
        logic [1:0] rsel;
        logic [1:0] nbytes;
        logic [3:0] cycles;
    } dec_t;

    localparam logic [3:0] IND_EXTRA = 4'd3;

endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
    import idx_ea_pkg::*;
(
    input  logic [7:0] pb,
    output dec_t       dec
);

    always_comb begin
        dec        = '0;
        dec.form   = FM_BAD;
        dec.rsel   = pb[6:5];
        dec.ind    = pb[7] & pb[4];
        if (!pb[7]) begin
            dec.form   = FM_OFS5;
            dec.cycles = 4'd1;
        end else if (pb == 8'h9F) begin
            dec.form   = FM_EXT;
            dec.nbytes = 2'd2;
            dec.cycles = 4'd5;
        end else begin
            unique case (pb[3:0])
                4'b0100: begin dec.form = FM_NONE;  dec.cycles = 4'd0; end
                4'b1000: begin dec.form = FM_OFS8;  dec.cycles = 4'd1; dec.nbytes = 2'd1; end
                4'b1001: begin dec.form = FM_OFS16; dec.cycles = 4'd4; dec.nbytes = 2'd2; end
                4'b0110: begin dec.form = FM_ACCA;  dec.cycles = 4'd1; end
                4'b0101: begin dec.form = FM_ACCB;  dec.cycles = 4'd1; end
                4'b1011: begin dec.form = FM_ACCD;  dec.cycles = 4'd4; end
                4'b0000: begin dec.form = FM_INC1;  dec.cycles = 4'd2; end
                4'b0001: begin dec.form = FM_INC2;  dec.cycles = 4'd3; end
                4'b0010: begin dec.form = FM_DEC1;  dec.cycles = 4'd2; end
                4'b0011: begin dec.form = FM_DEC2;  dec.cycles = 4'd3; end
                4'b1100: begin dec.form = FM_PC8;   dec.cycles = 4'd1; dec.nbytes = 2'd1; end
                4'b1101: begin dec.form = FM_PC16;  dec.cycles = 4'd5; dec.nbytes = 2'd2; end
                default: begin dec.bad = 1'b1; end
            endcase
            // single steps have no indirect variant
            if (dec.ind && (dec.form == FM_INC1 || dec.form == FM_DEC1)) begin
                dec.bad = 1'b1;
            end
            if (!dec.bad && dec.ind) begin
                dec.cycles = dec.cycles + IND_EXTRA;
            end
        end
        if (dec.bad) begin
            dec.form   = FM_BAD;
            dec.ind    = 1'b0;
            dec.cycles = '0;
            dec.nbytes = '0;
        end
    end

endmodule

// File: rtl/idx_ea_agen.sv
module idx_ea_agen
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  form_e          form,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  pc,
    input  logic [AW-1:0]  ofs,
    input  logic [4:0]     pb5,
    input  logic [DW-1:0]  acc_a,
    input  logic [DW-1:0]  acc_b,
    output logic [AW-1:0]  addr,
    output logic [AW-1:0]  wbv,
    output logic           wbn
);

    localparam int SXW = AW - DW;

    logic [AW-1:0] sx_ofs5;
    logic [AW-1:0] sx_ofs8;
    logic [AW-1:0] sx_a;
    logic [AW-1:0] sx_b;
    logic [AW-1:0] acc_d;

    assign sx_ofs5 = {{(AW-5){pb5[4]}}, pb5};
    assign sx_ofs8 = {{SXW{ofs[DW-1]}}, ofs[DW-1:0]};
    assign sx_a    = {{SXW{acc_a[DW-1]}}, acc_a};
    assign sx_b    = {{SXW{acc_b[DW-1]}}, acc_b};
    assign acc_d   = AW'({acc_a, acc_b});

    always_comb begin
        addr = base;
        wbv  = base;
        wbn  = 1'b0;
        unique case (form)
            FM_OFS5:  addr = base + sx_ofs5;
            FM_NONE:  addr = base;
            FM_OFS8:  addr = base + sx_ofs8;
            FM_OFS16: addr = base + ofs;
            FM_ACCA:  addr = base + sx_a;
            FM_ACCB:  addr = base + sx_b;
            FM_ACCD:  addr = base + acc_d;
            FM_INC1:  begin addr = base;        wbv = base + AW'(1); wbn = 1'b1; end
            FM_INC2:  begin addr = base;        wbv = base + AW'(2); wbn = 1'b1; end
            FM_DEC1:  begin addr = base - AW'(1); wbv = base - AW'(1); wbn = 1'b1; end
            FM_DEC2:  begin addr = base - AW'(2); wbv = base - AW'(2); wbn = 1'b1; end
            FM_PC8:   addr = pc + sx_ofs8;
            FM_PC16:  addr = pc + ofs;
            FM_EXT:   addr = ofs;
            default:  addr = base;
        endcase
    end

endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [7:0]     postbyte,
    input  logic [AW-1:0]  reg_x,
    input  logic [AW-1:0]  reg_y,
    input  logic [AW-1:0]  reg_u,
    input  logic [AW-1:0]  reg_s,
    input  logic [DW-1:0]  acc_a,
    input  logic [DW-1:0]  acc_b,
    input  logic [AW-1:0]  pc_next,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           done,
    output logic [AW-1:0]  ea,
    output logic [3:0]     extra_cycles,
    output logic [1:0]     extra_bytes,
    output logic           illegal,
    output logic           wb_en,
    output logic [1:0]     wb_sel,
    output logic [AW-1:0]  wb_value
);

    localparam int NREG  = 4;
    localparam int HIW   = AW - DW;
    localparam logic [1:0] PTR_BYTES = 2'(AW / DW);

    typedef struct packed {
        state_e        st;
        dec_t          dec;
        logic [4:0]    pb5;
        logic [AW-1:0] base;
        logic [AW-1:0] pc;
        logic [AW-1:0] ofs;
        logic [AW-1:0] ptr;
        logic [AW-1:0] ea;
        logic [AW-1:0] wbv;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [1:0]    cnt;
        logic          wbp;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    dec_t          dec_in;
    logic [AW-1:0] regs [NREG];
    logic [AW-1:0] ag_addr;
    logic [AW-1:0] ag_wbv;
    logic          ag_wbn;
    logic [AW-1:0] ofs_shift;

    assign regs[0] = reg_x;
    assign regs[1] = reg_y;
    assign regs[2] = reg_u;
    assign regs[3] = reg_s;

    idx_ea_decode u_dec (
        .pb  (postbyte),
        .dec (dec_in)
    );

    idx_ea_agen #(.AW(AW), .DW(DW)) u_agen (
        .form  (ctx_q.dec.form),
        .base  (ctx_q.base),
        .pc    (ctx_q.pc),
        .ofs   (ctx_q.ofs),
        .pb5   (ctx_q.pb5),
        .acc_a (ctx_q.a),
        .acc_b (ctx_q.b),
        .addr  (ag_addr),
        .wbv   (ag_wbv),
        .wbn   (ag_wbn)
    );

    // bytes arrive most significant first
    assign ofs_shift = {ctx_q.ofs[HIW-1:0], mem_rdata};

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctx_d.dec  = dec_in;
                    ctx_d.pb5  = postbyte[4:0];
                    ctx_d.base = regs[postbyte[6:5]];
                    ctx_d.pc   = pc_next;
                    ctx_d.a    = acc_a;
                    ctx_d.b    = acc_b;
                    ctx_d.ofs  = '0;
                    ctx_d.wbp  = 1'b0;
                    ctx_d.cnt  = dec_in.nbytes;
                    if (dec_in.bad) begin
                        ctx_d.ea = '0;
                        ctx_d.st = ST_DONE;
                    end else if (dec_in.nbytes != 2'd0) begin
                        ctx_d.st = ST_OFS;
                    end else begin
                        ctx_d.st = ST_CALC;
                    end
                end
            end
            ST_OFS: begin
                if (mem_ack) begin
                    ctx_d.ofs = ofs_shift;
                    ctx_d.pc  = ctx_q.pc + AW'(1);
                    ctx_d.cnt = ctx_q.cnt - 2'd1;
                    if (ctx_q.cnt == 2'd1) begin
                        ctx_d.st = ST_CALC;
                    end
                end
            end
            ST_CALC: begin
                ctx_d.ea  = ag_addr;
                ctx_d.wbv = ag_wbv;
                ctx_d.wbp = ag_wbn;
                if (ctx_q.dec.ind) begin
                    ctx_d.ptr = ag_addr;
                    ctx_d.ofs = '0;
                    ctx_d.cnt = PTR_BYTES;
                    ctx_d.st  = ST_PTR;
                end else begin
                    ctx_d.st  = ST_DONE;
                end
            end
            ST_PTR: begin
                if (mem_ack) begin
                    ctx_d.ofs = ofs_shift;
                    ctx_d.ptr = ctx_q.ptr + AW'(1);
                    ctx_d.cnt = ctx_q.cnt - 2'd1;
                    if (ctx_q.cnt == 2'd1) begin
                        ctx_d.ea = ofs_shift;
                        ctx_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign mem_req      = (ctx_q.st == ST_OFS) || (ctx_q.st == ST_PTR);
    assign mem_addr     = (ctx_q.st == ST_PTR) ? ctx_q.ptr : ctx_q.pc;
    assign done         = (ctx_q.st == ST_DONE);
    assign ea           = ctx_q.ea;
    assign extra_cycles = ctx_q.dec.cycles;
    assign extra_bytes  = ctx_q.dec.nbytes;
    assign illegal      = ctx_q.dec.bad;
    assign wb_en        = done && ctx_q.wbp;
    assign wb_sel       = ctx_q.dec.rsel;
    assign wb_value     = ctx_q.wbv;

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata,
    input logic          done,
    input logic [3:0]    extra_cycles,
    input logic [1:0]    extra_bytes,
    input logic          illegal,
    input logic          wb_en
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R11

    AST_WB_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done); // R5

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!wb_en && extra_cycles == 4'd0 && extra_bytes == 2'd0)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3

    AST_COST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (extra_cycles <= 4'd8 && extra_bytes <= 2'd2)); // R8

    logic unused_data;
    assign unused_data = ^mem_rdata;

endmodule

bind idx_ea_unit idx_ea_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .done         (done),
    .extra_cycles (extra_cycles),
    .extra_bytes  (extra_bytes),
    .illegal      (illegal),
    .wb_en        (wb_en)
);

// File: tb/idx_ea_unit_tb_top.sv
module idx_ea_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  postbyte = '0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_u = '0, reg_s = '0, pc_next = '0;
    logic [7:0]  acc_a = '0, acc_b = '0;
    logic        mem_req, mem_ack = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done, illegal, wb_en;
    logic [15:0] ea, wb_value;
    logic [3:0]  extra_cycles;
    logic [1:0]  extra_bytes, wb_sel;

    int n_checks = 0;
    int n_errs   = 0;
    int acc_cnt  = 0;
    int cyc_cnt  = 0;

    always #4 clk = ~clk;

    idx_ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
        .reg_x(reg_x), .reg_y(reg_y), .reg_u(reg_u), .reg_s(reg_s),
        .acc_a(acc_a), .acc_b(acc_b), .pc_next(pc_next),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .ea(ea), .extra_cycles(extra_cycles), .extra_bytes(extra_bytes),
        .illegal(illegal), .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return {memf(a), memf(a + 16'd1)};
    endfunction

    // memory responder with random acknowledge delay
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && ($urandom % 3 != 0)) begin
            mem_ack   <= 1'b1;
            mem_rdata <= memf(mem_addr);
            acc_cnt   <= acc_cnt + 1;
        end
    end

    typedef struct {
        logic [15:0] ea;
        logic [3:0]  cyc;
        logic [1:0]  nb;
        logic        ill;
        logic        wben;
        logic [15:0] wbv;
        int          nacc;
        string       tag;
    } exp_t;

    function automatic exp_t model(input logic [7:0] pb, input logic [15:0] rx, ry, ru, rs, pc,
                                   input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        logic [15:0] r, adr, o8, o16;
        logic ind;
        r = (pb[6:5] == 2'd0) ? rx : (pb[6:5] == 2'd1) ? ry : (pb[6:5] == 2'd2) ? ru : rs;
        e.ea = '0; e.cyc = '0; e.nb = '0; e.ill = 1'b0; e.wben = 1'b0; e.wbv = '0; e.nacc = 0;
        o8  = {{8{memf(pc)[7]}}, memf(pc)};
        o16 = rd16(pc);
        ind = pb[4];
        adr = r;
        if (!pb[7]) begin
            e.ea = r + {{11{pb[4]}}, pb[4:0]}; e.cyc = 4'd1; e.tag = "R2";
            return e;
        end
        if (pb == 8'h9F) begin
            e.ea = rd16(o16); e.cyc = 4'd5; e.nb = 2'd2; e.nacc = 4; e.tag = "R9";
            return e;
        end
        e.tag = ind ? "R8" : "R3";
        case (pb[3:0])
            4'h4: begin adr = r; e.cyc = 0; end
            4'h8: begin adr = r + o8; e.cyc = 1; e.nb = 1; end
            4'h9: begin adr = r + o16; e.cyc = 4; e.nb = 2; end
            4'h6: begin adr = r + {{8{a[7]}}, a}; e.cyc = 1; if (!ind) e.tag = "R4"; end
            4'h5: begin adr = r + {{8{b[7]}}, b}; e.cyc = 1; if (!ind) e.tag = "R4"; end
            4'hB: begin adr = r + {a, b}; e.cyc = 4; if (!ind) e.tag = "R4"; end
            4'h0: begin adr = r; e.wben = 1; e.wbv = r + 1; e.cyc = 2; e.ill = ind; e.tag = "R5"; end
            4'h1: begin adr = r; e.wben = 1; e.wbv = r + 2; e.cyc = 3; if (!ind) e.tag = "R5"; end
            4'h2: begin adr = r - 1; e.wben = 1; e.wbv = r - 1; e.cyc = 2; e.ill = ind; e.tag = "R6"; end
            4'h3: begin adr = r - 2; e.wben = 1; e.wbv = r - 2; e.cyc = 3; if (!ind) e.tag = "R6"; end
            4'hC: begin adr = pc + 16'd1 + o8; e.cyc = 1; e.nb = 1; if (!ind) e.tag = "R7"; end
            4'hD: begin adr = pc + 16'd2 + o16; e.cyc = 5; e.nb = 2; if (!ind) e.tag = "R7"; end
            default: e.ill = 1'b1;
        endcase
        if (e.ill) begin
            e.ea = '0; e.cyc = '0; e.nb = '0; e.wben = 1'b0; e.wbv = '0; e.tag = "R10";
            return e;
        end
        e.nacc = e.nb;
        if (ind) begin
            e.ea = rd16(adr); e.cyc = e.cyc + 4'd3; e.nacc = e.nacc + 2;
        end else begin
            e.ea = adr;
        end
        return e;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] pb, input bit extra_start);
        exp_t e;
        int a0, k;
        bit got;
        e = model(pb, reg_x, reg_y, reg_u, reg_s, pc_next, acc_a, acc_b);
        @(negedge clk);
        a0 = acc_cnt;
        postbyte = pb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        for (k = 0; k < 60; k++) begin
            if (done) begin got = 1'b1; break; end
            if (k == 0 && extra_start) begin
                start = 1'b1;
                postbyte = ~pb;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (!got) begin
            check("R11", "done timeout", 0, 1);
            return;
        end
        check(e.tag, "ea", ea, e.ea);
        check(e.tag, "extra_cycles", extra_cycles, e.cyc);
        check(e.tag, "extra_bytes", extra_bytes, e.nb);
        check("R10", "illegal", illegal, e.ill);
        check(e.tag, "wb_en", wb_en, e.wben);
        check(e.tag, "memory reads", acc_cnt - a0, e.nacc);
        if (e.wben) begin
            check(e.tag, "wb_value", wb_value, e.wbv);
            check("R1", "wb_sel", wb_sel, pb[6:5]);
        end
        @(negedge clk);
        check("R11", "done width", done, 0);
    endtask

    task automatic randomize_regs();
        reg_x = 16'($urandom); reg_y = 16'($urandom);
        reg_u = 16'($urandom); reg_s = 16'($urandom);
        acc_a = 8'($urandom);  acc_b = 8'($urandom);
        pc_next = 16'($urandom);
    endtask

    initial begin
        logic [7:0] dir [24];
        dir = '{8'h9F, 8'h90, 8'h92, 8'h87, 8'h8A, 8'h8E, 8'hFF, 8'hBF,
                8'h1F, 8'h10, 8'h0F, 8'h8B, 8'hAD, 8'h86, 8'hF1, 8'hD3,
                8'h80, 8'hA2, 8'h9C, 8'hE4, 8'h99, 8'h95, 8'h0C, 8'h6C};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11", "reset done", done, 0);
        check("R11", "reset mem_req", mem_req, 0);
        check("R11", "reset wb_en", wb_en, 0);
        rst_n = 1'b1;
        // directed corners
        reg_x = 16'h0000; reg_y = 16'hFFFF; reg_u = 16'h8000; reg_s = 16'h7FFF;
        acc_a = 8'h80; acc_b = 8'h7F; pc_next = 16'hFFFE;
        foreach (dir[i]) run_one(dir[i], (i % 2) == 1);
        // PC-relative with different register bits must agree
        randomize_regs();
        run_one(8'h8C, 1'b0);
        run_one(8'hEC, 1'b0);
        // constrained random: bias toward indirect double steps
        for (int n = 0; n < 400; n++) begin
            logic [7:0] pb;
            randomize_regs();
            pb = 8'($urandom);
            if ($urandom % 4 == 0) pb = {1'b1, pb[6:5], 1'b1, 3'b000, pb[0]} | 8'h01;
            if ($urandom % 5 == 0) pb = {1'b1, pb[6:5], 1'b1, 4'b0011};
            run_one(pb, ($urandom % 3) == 0);
        end
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        wait (cyc_cnt > 150000);
        n_errs++;
        n_checks++;
        $display("FAIL R11 watchdog actual=%0d expected=<150000", cyc_cnt);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule